// File: doc/BRIEF.md
# Tree-Path Misprediction Recovery Selector

This block chooses a replacement path for a four-path prediction tree after one of the conditional branches on the predicted path turns out to be wrong. A tree holds up to two conditional branches on any path from its root. Its four paths carry the 2-bit codes 00, 01, 10 and 11. The high bit is the direction of the first branch and the low bit is the direction of the second. The recovery logic presents the failed prediction, the position of the faulty branch, the direction the branch actually took, and the four saturating counters of the second-level pattern entry that produced the original guess.

A wrong second branch leaves no choice, so the new path follows from a single bit inversion and the counters are not used. A wrong first branch fixes the high bit to the actual direction, but the second branch on the new side has no outcome yet. For that case the block takes the larger counter of the two paths on that side, and a tie goes to the lower-numbered path. The result is registered and arrives with a valid strobe one clock after the request. A flag marks whether the choice depended on the counter table, so the surrounding pipeline knows whether a second-level read had to be scheduled.

Top module: `tree_recover_sel`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rsp_valid`, `new_path` and `table_used` are all 0.
- R2: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` = 1 and is 0 after a cycle with `req_valid` = 0.
- R3: When `miss_pos` = 1 (second branch), `new_path` is `{old_path[1], ~old_path[0]}`.
- R4: When `miss_pos` = 1, `table_used` is 0 and the counter values have no effect on `new_path`.
- R5: When `miss_pos` = 0 (first branch) and `taken` = 1, `new_path` is 3 if counter 3 is greater than counter 2, and 2 otherwise. Counter k sits at bits `[k*CNT_W +: CNT_W]` of `cnt_vec`.
- R6: When `miss_pos` = 0 and `taken` = 0, `new_path` is 1 if counter 1 is greater than counter 0, and 0 otherwise.
- R7: With `TIE_LOW` = 1 (the default), equal counters in the compared pair select the lower path: 2 for a taken recovery and 0 for a not-taken recovery.
- R8: When `miss_pos` = 0, `table_used` is 1.
- R9: In a cycle after `req_valid` = 0, `new_path` and `table_used` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Recovery request strobe |
| old_path | input | 2 | Path code that was predicted and failed |
| miss_pos | input | 1 | 0: first branch of the path was wrong, 1: second branch |
| taken | input | 1 | Actual direction of the wrong branch (1 = taken) |
| cnt_vec | input | 4*CNT_W | Four counters of the pattern entry, counter k at `[k*CNT_W +: CNT_W]` |
| rsp_valid | output | 1 | New path is valid this cycle |
| new_path | output | 2 | Replacement path code |
| table_used | output | 1 | 1 when the choice depended on the counters |

## Verification
The hardest condition to reach is the tie between the two counters of the selected pair. The losing counters of the other pair also have to be shown to have no effect. Random counter values seldom give equal pairs, and with random values R4 becomes a weak check. For both directions, the bench therefore sweeps every combination of the two relevant counter values at a small counter width, which covers every tie. The bench also sets the counters of the unselected pair to their extremes. Second-branch requests are run for every old path, with both counter sets pulled to opposite extremes, so a counter that leaked into the result would change the output.

// File: rtl/tree_recover_pkg.sv
package tree_recover_pkg;
   localparam int PATH_W    = 2;
   localparam int NUM_PATHS = 1 << PATH_W;
   localparam int NUM_HALF  = NUM_PATHS / 2;

   typedef logic [PATH_W-1:0] path_t;

   // branch position codes on miss_pos
   localparam logic POS_FIRST  = 1'b0;
   localparam logic POS_SECOND = 1'b1;
endpackage

// File: rtl/trs_pair_pick.sv
module trs_pair_pick #(
   parameter int CNT_W   = 3,
   parameter bit TIE_LOW = 1'b1
) (
   input  logic [CNT_W-1:0] cnt_lo,
   input  logic [CNT_W-1:0] cnt_hi,
   output logic             pick_hi
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("trs_pair_pick: CNT_W must be at least 1");
      end
      if (TIE_LOW) begin : g_tie_low
         assign pick_hi = (cnt_hi > cnt_lo);
      end else begin : g_tie_high
         assign pick_hi = (cnt_hi >= cnt_lo);
      end
   endgenerate
endmodule

// File: rtl/trs_next_path.sv
module trs_next_path
   import tree_recover_pkg::*;
#(
   parameter int CNT_W   = 3,
   parameter bit TIE_LOW = 1'b1
) (
   input  path_t                      old_path,
   input  logic                       miss_pos,
   input  logic                       taken,
   input  logic [NUM_PATHS*CNT_W-1:0] cnt_vec,
   output path_t                      nxt_path,
   output logic                       nxt_used
);
   logic [NUM_HALF-1:0] half_hi;

   generate
      for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
         trs_pair_pick #(
            .CNT_W  (CNT_W),
            .TIE_LOW(TIE_LOW)
         ) u_pick (
            .cnt_lo (cnt_vec[(2*h)*CNT_W +: CNT_W]),
            .cnt_hi (cnt_vec[(2*h+1)*CNT_W +: CNT_W]),
            .pick_hi(half_hi[h])
         );
      end
   endgenerate

   always_comb begin
      if (miss_pos == POS_SECOND) begin
         nxt_path = {old_path[1], ~old_path[0]};
         nxt_used = 1'b0;
      end else begin
         nxt_path = {taken, half_hi[taken]};
         nxt_used = 1'b1;
      end
   end
endmodule

// File: rtl/tree_recover_sel.sv
module tree_recover_sel
   import tree_recover_pkg::*;
#(
   parameter int CNT_W   = 3,
   parameter bit TIE_LOW = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           old_path,
   input  logic                 miss_pos,
   input  logic                 taken,
   input  logic [4*CNT_W-1:0]   cnt_vec,
   output logic                 rsp_valid,
   output logic [1:0]           new_path,
   output logic                 table_used
);
   generate
      if (NUM_PATHS != 4) begin : g_bad_paths
         $error("tree_recover_sel: four tree paths expected");
      end
   endgenerate

   path_t nxt_path;
   logic  nxt_used;

   trs_next_path #(
      .CNT_W  (CNT_W),
      .TIE_LOW(TIE_LOW)
   ) u_next (
      .old_path(old_path),
      .miss_pos(miss_pos),
      .taken   (taken),
      .cnt_vec (cnt_vec),
      .nxt_path(nxt_path),
      .nxt_used(nxt_used)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         new_path   <= '0;
         table_used <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            new_path   <= nxt_path;
            table_used <= nxt_used;
         end
      end
   end
endmodule

// File: rtl/tree_recover_sel_chk.sv
module tree_recover_sel_chk #(
   parameter int CNT_W   = 3,
   parameter bit TIE_LOW = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [1:0]         old_path,
   input logic               miss_pos,
   input logic               taken,
   input logic [4*CNT_W-1:0] cnt_vec,
   input logic               rsp_valid,
   input logic [1:0]         new_path,
   input logic               table_used
);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && new_path == 2'b00 && !table_used));

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r3_low_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && miss_pos) |=>
         (new_path == {$past(old_path[1]), ~$past(old_path[0])}));

   a_r4_no_table: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && miss_pos) |=> !table_used);

   a_r5_taken_side: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !miss_pos && taken) |=> new_path[1]);

   a_r6_nottaken_side: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !miss_pos && !taken) |=> !new_path[1]);

   a_r7_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
      (TIE_LOW && req_valid && !miss_pos &&
       cnt_vec[(2*taken)*CNT_W +: CNT_W] == cnt_vec[(2*taken+1)*CNT_W +: CNT_W])
      |=> !new_path[0]);

   a_r8_table_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !miss_pos) |=> table_used);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(new_path) && $stable(table_used)));
endmodule

bind tree_recover_sel tree_recover_sel_chk #(
   .CNT_W  (CNT_W),
   .TIE_LOW(TIE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .old_path  (old_path),
   .miss_pos  (miss_pos),
   .taken     (taken),
   .cnt_vec   (cnt_vec),
   .rsp_valid (rsp_valid),
   .new_path  (new_path),
   .table_used(table_used)
);

// File: tb/tree_recover_sel_test.sv
module tree_recover_sel_test;
   localparam int CNT_W = 3;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [1:0]         old_path = 2'b00;
   logic               miss_pos = 1'b0;
   logic               taken = 1'b0;
   logic [4*CNT_W-1:0] cnt_vec = '0;
   logic               rsp_valid;
   logic [1:0]         new_path;
   logic               table_used;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   tree_recover_sel #(.CNT_W(CNT_W), .TIE_LOW(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .old_path(old_path),
      .miss_pos(miss_pos), .taken(taken), .cnt_vec(cnt_vec),
      .rsp_valid(rsp_valid), .new_path(new_path), .table_used(table_used)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [4*CNT_W-1:0] pack(input int c0, input int c1,
                                               input int c2, input int c3);
      logic [4*CNT_W-1:0] v;
      v[0*CNT_W +: CNT_W] = CNT_W'(c0);
      v[1*CNT_W +: CNT_W] = CNT_W'(c1);
      v[2*CNT_W +: CNT_W] = CNT_W'(c2);
      v[3*CNT_W +: CNT_W] = CNT_W'(c3);
      return v;
   endfunction

   // one request, result sampled at the following negedge
   task automatic run_req(input int op, input bit pos, input bit tk,
                          input int c0, input int c1, input int c2, input int c3);
      int exp;
      @(negedge clk);
      req_valid = 1'b1;
      old_path  = 2'(op);
      miss_pos  = pos;
      taken     = tk;
      cnt_vec   = pack(c0, c1, c2, c3);
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 valid strobe", int'(rsp_valid), 1);
      if (pos) begin
         exp = (op & 2) | ((op & 1) ^ 1);
         check("R3 second-branch flip", int'(new_path), exp);
         check("R4 no table read", int'(table_used), 0);
      end else begin
         if (tk) exp = (c3 > c2) ? 3 : 2;
         else    exp = (c1 > c0) ? 1 : 0;
         if (tk && c2 == c3)       check("R7 tie taken", int'(new_path), 2);
         else if (!tk && c0 == c1) check("R7 tie not-taken", int'(new_path), 0);
         else if (tk)              check("R5 taken max", int'(new_path), exp);
         else                      check("R6 not-taken max", int'(new_path), exp);
         check("R8 table read", int'(table_used), 1);
      end
   endtask

   initial begin
      int prev_path;
      int prev_used;
      repeat (3) @(negedge clk);
      check("R1 reset valid", int'(rsp_valid), 0);
      check("R1 reset path", int'(new_path), 0);
      check("R1 reset flag", int'(table_used), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first cycle valid", int'(rsp_valid), 0);
      check("R1 first cycle path", int'(new_path), 0);

      // second-branch recovery: every old path, counters at opposite extremes
      for (int op = 0; op < 4; op++) begin
         for (int tk = 0; tk < 2; tk++) begin
            run_req(op, 1'b1, tk[0], CMAX, 0, CMAX, 0);
            run_req(op, 1'b1, tk[0], 0, CMAX, 0, CMAX);
         end
      end

      // first-branch recovery: full sweep of the relevant pair
      for (int a = 0; a <= CMAX; a++) begin
         for (int b = 0; b <= CMAX; b++) begin
            run_req(a % 4, 1'b0, 1'b1, CMAX, 0, a, b);
            run_req((a + b) % 4, 1'b0, 1'b0, a, b, 0, CMAX);
         end
      end

      // R9: idle cycles with busy inputs leave the result unchanged
      run_req(0, 1'b0, 1'b1, 0, 0, 1, 5);
      prev_path = int'(new_path);
      prev_used = int'(table_used);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         old_path = 2'(i);
         miss_pos = i[0];
         taken    = i[1];
         cnt_vec  = pack(i, CMAX - i, CMAX, 0);
         @(negedge clk);
         check("R2 no strobe when idle", int'(rsp_valid), 0);
         check("R9 path held", int'(new_path), prev_path);
         check("R9 flag held", int'(table_used), prev_used);
      end

      // back-to-back requests
      @(negedge clk);
      req_valid = 1'b1; miss_pos = 1'b1; old_path = 2'b10; cnt_vec = '0;
      @(negedge clk);
      check("R3 back-to-back first", int'(new_path), 3);
      miss_pos = 1'b0; taken = 1'b0; cnt_vec = pack(2, 6, 0, 0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 back-to-back valid", int'(rsp_valid), 1);
      check("R6 back-to-back second", int'(new_path), 1);
      @(negedge clk);
      check("R2 strobe drops", int'(rsp_valid), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule